// File: doc/BRIEF.md
# Output Short-Circuit Retry Latch

This block supervises the power-bridge outputs of a motor driver against output shorts. A digital short-detect flag from the analog comparators drives it. The flag counts only after it has been high on several consecutive clock edges. When it counts, the block disables the bridge and waits a fixed off period. It then enables the bridge once more and watches for a re-check window.

If the short shows up again during that window, the block parks the driver in a latched standby state and raises a fault flag. The only way out of that state is to pull the chip-enable input low; there is no other path back. If the window passes with no short, normal operation resumes, and a later short gets a fresh retry.

All timing is counted in system clocks. The filter length, the off period (nominally 256 µs) and the re-check window are parameters. The re-check window must be at least as long as the filter.

Top module: `short_retry_latch`

## Requirements
- R1: After power-on reset, with chip-enable high and no short, `bridgeOn` is 1 and `faultFlag` is 0.
- R2: A short-detect pulse that is high on fewer than FILT_CYCLES consecutive rising edges is ignored: `bridgeOn` stays 1 and `faultFlag` stays 0.
- R3: When short-detect has been high on FILT_CYCLES consecutive rising edges with the bridge on, `bridgeOn` is 0 right after the last of those edges.
- R4: After a qualified short in normal operation, `bridgeOn` stays 0 for exactly OFF_CYCLES clock cycles and then returns to 1, with `faultFlag` still 0.
- R5: A qualified short during the re-check window sets `faultFlag` to 1 and `bridgeOn` to 0 right after the qualifying edge.
- R6: If no short qualifies within CHECK_CYCLES cycles of the retry, the block returns to normal. A later short then starts a new off period instead of latching.
- R7: While latched with chip-enable high, `faultFlag` stays 1 and `bridgeOn` stays 0 whatever short-detect does.
- R8: Chip-enable low forces `bridgeOn` to 0 at once and clears `faultFlag` at the next rising edge. When chip-enable is high again, `bridgeOn` is 1.
- R9: Chip-enable low during the off period cancels the retry sequence, and the block returns to normal operation.
- R10: Short-detect is ignored while the bridge is off. The filter restarts from zero when the retry begins, so a short held throughout the off period needs FILT_CYCLES more edges in the window before it latches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| chipEn | input | 1 | Chip enable; low means standby and releases the latch |
| shortDet | input | 1 | Raw short-detect flag from the analog comparators, synchronous to clk |
| bridgeOn | output | 1 | High when the bridge outputs may conduct |
| faultFlag | output | 1 | High while the driver is latched off by a persistent short |

## Verification
The assertions assume short-detect and chip-enable are already synchronous to the clock and change only between edges. They also assume the re-check window is no shorter than the filter, so a persistent short can qualify before the window closes. The bench drives both inputs just after the falling edge. It holds random short-detect levels for bursts of one to several cycles, so the random phase produces both filtered glitches and qualified shorts. Brief chip-enable drops in that phase land in every state.

// File: rtl/short_retry_pkg.sv
package short_retry_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL      = 2'd0,
    ST_OFF_WAIT    = 2'd1,
    ST_RETRY_CHECK = 2'd2,
    ST_LATCHED     = 2'd3
  } protState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic timerClr;
    logic filtClr;
  } ctrlStrobe_s;

  // status from datapath to control
  typedef struct packed {
    logic shortQual;
    logic offDone;
    logic checkDone;
  } dpStatus_s;

endpackage

// File: rtl/short_retry_dp.sv
module short_retry_dp
  import short_retry_pkg::*;
#(
  parameter int FILT_CYCLES  = 3,
  parameter int OFF_CYCLES   = 51200,
  parameter int CHECK_CYCLES = 2048
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        shortDet,
  input  ctrlStrobe_s strobe,
  output dpStatus_s   status
);

  localparam int TIMER_MAX = (OFF_CYCLES > CHECK_CYCLES) ? OFF_CYCLES : CHECK_CYCLES;
  localparam int TW        = $clog2(TIMER_MAX + 1);
  localparam int FW        = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES + 1) : 1;
  localparam logic [FW-1:0] FILT_LAST = FW'(FILT_CYCLES - 1);
  localparam logic [TW-1:0] OFF_LAST  = TW'(OFF_CYCLES - 1);
  localparam logic [TW-1:0] CHK_LAST  = TW'(CHECK_CYCLES - 1);
  localparam logic [TW-1:0] TMR_TOP   = TW'(TIMER_MAX);

  logic [FW-1:0] filtCnt;
  logic [TW-1:0] timerQ;

  // consecutive-sample glitch filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtCnt <= '0;
    end else if (strobe.filtClr || !shortDet) begin
      filtCnt <= '0;
    end else if (filtCnt != FILT_LAST) begin
      filtCnt <= filtCnt + 1'b1;
    end
  end

  // shared phase timer, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerQ <= '0;
    end else if (strobe.timerClr) begin
      timerQ <= '0;
    end else if (timerQ != TMR_TOP) begin
      timerQ <= timerQ + 1'b1;
    end
  end

  always_comb begin
    status.shortQual = shortDet && !strobe.filtClr && (filtCnt == FILT_LAST);
    status.offDone   = (timerQ == OFF_LAST);
    status.checkDone = (timerQ == CHK_LAST);
  end

endmodule

// File: rtl/short_retry_ctrl.sv
module short_retry_ctrl
  import short_retry_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chipEn,
  input  dpStatus_s   status,
  output ctrlStrobe_s strobe,
  output logic        bridgeOn,
  output logic        faultFlag
);

  protState_e stateQ, stateNxt;

  always_comb begin
    stateNxt = stateQ;
    unique case (stateQ)
      ST_NORMAL:      if (status.shortQual) stateNxt = ST_OFF_WAIT;
      ST_OFF_WAIT:    if (status.offDone)   stateNxt = ST_RETRY_CHECK;
      ST_RETRY_CHECK: begin
        if (status.shortQual)      stateNxt = ST_LATCHED;
        else if (status.checkDone) stateNxt = ST_NORMAL;
      end
      ST_LATCHED:     stateNxt = ST_LATCHED;
      default:        stateNxt = ST_NORMAL;
    endcase
    if (!chipEn) stateNxt = ST_NORMAL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_NORMAL;
    else       stateQ <= stateNxt;
  end

  always_comb begin
    bridgeOn        = chipEn && (stateQ == ST_NORMAL || stateQ == ST_RETRY_CHECK);
    faultFlag       = (stateQ == ST_LATCHED);
    strobe.filtClr  = !bridgeOn;
    strobe.timerClr = (stateNxt != stateQ) || (stateQ == ST_NORMAL) || (stateQ == ST_LATCHED);
  end

endmodule

// File: rtl/short_retry_latch.sv
module short_retry_latch
  import short_retry_pkg::*;
#(
  parameter int FILT_CYCLES  = 3,
  parameter int OFF_CYCLES   = 51200,
  parameter int CHECK_CYCLES = 2048
) (
  input  logic clk,
  input  logic rstN,
  input  logic chipEn,
  input  logic shortDet,
  output logic bridgeOn,
  output logic faultFlag
);

  ctrlStrobe_s strobe;
  dpStatus_s   status;

  short_retry_dp #(
    .FILT_CYCLES (FILT_CYCLES),
    .OFF_CYCLES  (OFF_CYCLES),
    .CHECK_CYCLES(CHECK_CYCLES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .shortDet(shortDet),
    .strobe  (strobe),
    .status  (status)
  );

  short_retry_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .chipEn   (chipEn),
    .status   (status),
    .strobe   (strobe),
    .bridgeOn (bridgeOn),
    .faultFlag(faultFlag)
  );

endmodule

// File: rtl/short_retry_latch_chk.sv
module short_retry_latch_chk #(
  parameter int OFF_CYCLES = 51200
) (
  input logic clk,
  input logic rstN,
  input logic chipEn,
  input logic shortDet,
  input logic bridgeOn,
  input logic faultFlag
);

  int offRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              offRun <= 0;
    else if (bridgeOn || !chipEn || faultFlag) offRun <= 0;
    else                                    offRun <= offRun + 1;
  end

  AST_TRIP_NEEDS_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bridgeOn) && chipEn && $past(chipEn) |-> $past(shortDet)); // R3
  AST_OFF_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bridgeOn) && chipEn && $past(chipEn) |-> offRun == OFF_CYCLES); // R4
  AST_LATCH_FROM_RETRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultFlag) |-> $past(bridgeOn)); // R5
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    faultFlag && chipEn |=> faultFlag); // R7
  AST_FAULT_OUTPUT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    faultFlag |-> !bridgeOn); // R7
  AST_STANDBY_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |-> !bridgeOn); // R8
  AST_STANDBY_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |=> !faultFlag); // R8

endmodule

bind short_retry_latch short_retry_latch_chk #(.OFF_CYCLES(OFF_CYCLES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .chipEn   (chipEn),
  .shortDet (shortDet),
  .bridgeOn (bridgeOn),
  .faultFlag(faultFlag)
);

// File: tb/short_retry_latch_tb.sv
`timescale 1ns/1ps
module short_retry_latch_tb;

  localparam int FILT  = 3;
  localparam int OFFC  = 40;
  localparam int CHKC  = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipEn = 1'b1;
  logic shortDet = 1'b0;
  logic bridgeOn, faultFlag;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  short_retry_latch #(
    .FILT_CYCLES (FILT),
    .OFF_CYCLES  (OFFC),
    .CHECK_CYCLES(CHKC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .shortDet(shortDet),
    .bridgeOn(bridgeOn), .faultFlag(faultFlag)
  );

  // reference model written from the requirements: 0 normal,1 off,2 retry,3 latched
  int mState = 0, mFilt = 0, mTime = 0, mNext = 0;
  bit mOn, mQual;
  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mFilt = 0; mTime = 0;
    end else begin
      mOn   = chipEn && (mState == 0 || mState == 2);
      mQual = mOn && shortDet && (mFilt == FILT - 1);
      mNext = mState;
      if (mState == 0 && mQual) mNext = 1;
      else if (mState == 1 && mTime == OFFC - 1) mNext = 2;
      else if (mState == 2 && mQual) mNext = 3;
      else if (mState == 2 && mTime == CHKC - 1) mNext = 0;
      if (!chipEn) mNext = 0;
      if (!mOn || !shortDet) mFilt = 0;
      else if (mFilt < FILT - 1) mFilt = mFilt + 1;
      mTime  = (mNext != mState) ? 0 : mTime + 1;
      mState = mNext;
    end
  end

  function automatic logic expOn(logic ce, int st);
    return ce && (st == 0 || st == 2);
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive at negedge, let one rising edge sample, return at next negedge
  task automatic step(logic s, logic ce);
    shortDet = s;
    chipEn   = ce;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 bridgeOn after reset", bridgeOn, 1'b1);
    check("R1 faultFlag after reset", faultFlag, 1'b0);

    // R2: pulse one edge short of the filter length
    for (int i = 0; i < FILT - 1; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b1);
      check("R2 short glitch ignored", bridgeOn, 1'b1);
    end

    // R3: qualified short trips on the FILT-th edge
    for (int i = 1; i <= FILT; i++) begin
      step(1'b1, 1'b1);
      check("R3 trip timing", bridgeOn, (i < FILT) ? 1'b1 : 1'b0);
    end

    // R4: exact off period, then retry with bridge on
    for (int k = 1; k <= OFFC; k++) begin
      step(1'b0, 1'b1);
      check("R4 off window", bridgeOn, (k == OFFC) ? 1'b1 : 1'b0);
    end
    check("R4 no fault after retry", faultFlag, 1'b0);

    // R6: clean window returns to normal
    for (int k = 1; k <= CHKC; k++) step(1'b0, 1'b1);
    check("R6 still on after window", bridgeOn, 1'b1);
    for (int i = 1; i <= FILT; i++) step(1'b1, 1'b1);
    check("R6 new short trips again", bridgeOn, 1'b0);
    check("R6 new short does not latch", faultFlag, 1'b0);

    // R10 and R5: short held across off period, filter restarts in retry
    for (int k = 1; k <= OFFC + FILT; k++) begin
      step(1'b1, 1'b1);
      if (k < OFFC)
        check("R10 off while short held", bridgeOn, 1'b0);
      else if (k < OFFC + FILT)
        check("R10 filter restarts in retry", bridgeOn, 1'b1);
      else begin
        check("R5 latched bridge off", bridgeOn, 1'b0);
        check("R5 fault asserted", faultFlag, 1'b1);
      end
    end

    // R7: latch holds under any short activity
    for (int i = 0; i < 20; i++) begin
      step(1'($urandom_range(0, 1)), 1'b1);
      check("R7 fault holds", faultFlag, 1'b1);
      check("R7 bridge held off", bridgeOn, 1'b0);
    end

    // R8: chip enable releases latch
    step(1'b0, 1'b0);
    check("R8 bridge off in standby", bridgeOn, 1'b0);
    check("R8 fault cleared", faultFlag, 1'b0);
    step(1'b0, 1'b1);
    check("R8 bridge back on", bridgeOn, 1'b1);
    check("R8 fault stays clear", faultFlag, 1'b0);

    // R9: chip enable low during off period cancels retry
    for (int i = 0; i < FILT; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1);
    check("R9 in off period", bridgeOn, 1'b0);
    step(1'b0, 1'b0);
    for (int k = 0; k < OFFC + CHKC + 5; k++) begin
      step(1'b0, 1'b1);
      check("R9 normal after cancel", bridgeOn, 1'b1);
    end

    // random bursts against the reference model (R3 R4 R5 R6 R8)
    begin
      int hold = 0;
      logic s = 1'b0;
      logic ce = 1'b1;
      for (int i = 0; i < 6000; i++) begin
        if (hold == 0) begin
          s    = ($urandom_range(0, 3) == 0);
          hold = $urandom_range(1, 6);
          ce   = ($urandom_range(0, 60) != 0);
        end
        hold--;
        step(s, ce);
        check("R5 model bridgeOn", bridgeOn, expOn(chipEn, mState));
        check("R8 model faultFlag", faultFlag, (mState == 3) ? 1'b1 : 1'b0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule